// File: doc/BRIEF.md
# Two-Stage Reload Watchdog Timer

This block is a system watchdog built on a 10-bit down-counter that moves one step for every timer tick it is given. Each tick stands for 0.6 s of real time. Software sets a start value and must keep reloading the counter. If the counter runs out once, the block raises a timeout flag, pulses an interrupt and starts a fresh countdown from the start value. If the counter runs out again while that flag is still set, the block raises a second-timeout flag and asks for a system reset. A no-reboot mask can hold back that reset request, and the flags still update while it is set.

Software clears the first timeout flag to re-arm the double countdown. Start values below 4 are rejected. A halt bit freezes the count. After power-on the timer is halted and the mask is set, so nothing happens until software releases the timer. The register bus is 16 bits wide, with separate write and read strobes. Read data is registered and appears one clock after the read strobe.

Top module: `wdt_twostage`

## Requirements
- R1: After reset, control (offset 0x08) reads 0x0801 (halt bit 11 = 1, no-reboot mask bit 0 = 1). The start value (0x12) reads 4, the count (0x00) reads 4, both status registers read 0, and the interrupt and reset request outputs are 0.
- R2: On each clock with `tick_en` = 1 and halt = 0, the count drops by one. With halt = 1 or `tick_en` = 0 the count holds.
- R3: Any write to offset 0x00 loads the counter from the start value. A read of 0x00 returns the count in bits 9:0, with bits 15:10 reading 0. When such a write and a tick fall in the same cycle, the load wins and no expiry happens.
- R4: A write to 0x12 whose bits 9:0 hold a value from 4 to 1023 replaces the start value. A write of 0 to 3 is ignored. Bits 15:10 of the written word are not stored and read as 0.
- R5: Control bits 11 (halt) and 0 (no-reboot mask) read back as written. All other control bits read 0.
- R6: A tick that finds the count at 0 while status bit 3 (offset 0x04) is clear is a first expiry. It sets that bit, reloads the counter from the start value, and drives `irq_o` high for exactly one clock.
- R7: Status bit 3 at 0x04 is cleared only by writing a 1 to bit 3. Writing 0 to it leaves it unchanged.
- R8: A tick that finds the count at 0 while status bit 3 is set is a second expiry. It sets bit 1 of the second status register (0x06) and reloads the counter, with no interrupt. If the mask is clear, it also asserts `sys_rst_req_o` and sets the boot flag in bit 2 of 0x06.
- R9: With the no-reboot mask set, a second expiry still sets 0x06 bit 1 but does not assert `sys_rst_req_o` and does not set the boot flag.
- R10: Once asserted, `sys_rst_req_o` stays high until `rst_n` is asserted, regardless of any register write.
- R11: Bits 1 and 2 of 0x06 are each cleared by writing 1 to that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle marker of a timer tick |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | One-cycle pulse on a first expiry |
| sys_rst_req_o | output | 1 | Sticky system reset request |

## Verification
The in-line assertions watch, on every cycle:
- that the reset request never drops;
- that the interrupt never lasts more than one clock;
- that the count holds while halted and otherwise steps by one per tick;
- that a bus load yields the start value;
- that the start value never falls below 4;
- that the second-timeout flag only rises while the first flag is set;
- that the reset request only rises when the mask was clear.

Only the bench scenarios can show the rest:
- the complete double-expiry sequence;
- the write-1-to-clear behaviour and the ignored zero writes;
- the rejection of short start values;
- the load-versus-tick collision at zero;
- the register read-back through the bus.

// File: rtl/wdt_pkg.sv
// Package: shared constants for the two-stage watchdog.
// Assumes a 16-bit register bus addressed by byte offset.
package wdt_pkg;
    localparam int CNT_W    = 10;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int MIN_LOAD = 4;
    localparam int RST_LOAD = 4;

    localparam logic [ADDR_W-1:0] OFF_COUNT = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_STS_A = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_STS_B = 5'h06;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_START = 5'h12;

    localparam int BIT_HALT   = 11;
    localparam int BIT_MASK   = 0;
    localparam int BIT_FIRST  = 3;
    localparam int BIT_SECOND = 1;
    localparam int BIT_BOOT   = 2;
endpackage

// File: rtl/wdt_regs.sv
// Module: register decode, control/start-value storage and read mux.
// Assumes one bus access per cycle; read data is registered.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int MIN = MIN_LOAD,
    parameter int RST = RST_LOAD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] count,
    input  logic          first_flag,
    input  logic          second_flag,
    input  logic          boot_flag,
    output logic [DW-1:0] rdata,
    output logic          reload,
    output logic          halt,
    output logic          mask,
    output logic [CW-1:0] start_val,
    output logic          clr_first,
    output logic          clr_second,
    output logic          clr_boot
);
    localparam logic [CW-1:0] MIN_V = CW'(MIN);
    localparam logic [CW-1:0] RST_V = CW'(RST);

    logic [DW-1:0] rd_mux;
    logic          unused_wdata;

    assign unused_wdata = ^wdata;

    // Write strobes decoded per register.
    assign reload     = wr && (addr == OFF_COUNT);
    assign clr_first  = wr && (addr == OFF_STS_A) && wdata[BIT_FIRST];
    assign clr_second = wr && (addr == OFF_STS_B) && wdata[BIT_SECOND];
    assign clr_boot   = wr && (addr == OFF_STS_B) && wdata[BIT_BOOT];

    // Control bits: halt and no-reboot mask, both set at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt <= 1'b1;
            mask <= 1'b1;
        end else if (wr && addr == OFF_CTRL) begin
            halt <= wdata[BIT_HALT];
            mask <= wdata[BIT_MASK];
        end
    end

    // Start value: accepts only loads at or above the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_val <= RST_V;
        end else if (wr && addr == OFF_START && wdata[CW-1:0] >= MIN_V) begin
            start_val <= wdata[CW-1:0];
        end
    end

    // Read multiplexer over the register offsets.
    always_comb begin
        rd_mux = '0;
        case (addr)
            OFF_COUNT: rd_mux[CW-1:0]     = count;
            OFF_STS_A: rd_mux[BIT_FIRST]  = first_flag;
            OFF_STS_B: begin
                rd_mux[BIT_SECOND] = second_flag;
                rd_mux[BIT_BOOT]   = boot_flag;
            end
            OFF_CTRL: begin
                rd_mux[BIT_HALT] = halt;
                rd_mux[BIT_MASK] = mask;
            end
            OFF_START: rd_mux[CW-1:0] = start_val;
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    AST_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        start_val >= MIN_V); // R4
endmodule

// File: rtl/wdt_counter.sv
// Module: the down-counter; flags expiry on a tick at zero.
// Assumes start_val is never below the minimum legal load.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int RST = RST_LOAD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          halt,
    input  logic          reload,
    input  logic [CW-1:0] start_val,
    output logic [CW-1:0] count,
    output logic          expire
);
    logic step;

    // A live tick: not halted and not overridden by a bus load.
    assign step   = tick_en && !halt && !reload;
    assign expire = step && (count == '0);

    // Count update: bus load first, then expiry reload, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                   count <= CW'(RST);
        else if (reload || expire)    count <= start_val;
        else if (step)                count <= count - 1'b1;
    end

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(count)); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !halt && !reload && count != '0) |=> (count == $past(count) - 1'b1)); // R2
    AST_BUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == $past(start_val))); // R3
endmodule

// File: rtl/wdt_expiry.sv
// Module: status flags, interrupt pulse and gated sticky reset request.
// Assumes expire is a single-cycle event; a set beats a same-cycle clear.
module wdt_expiry (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic mask,
    input  logic clr_first,
    input  logic clr_second,
    input  logic clr_boot,
    output logic first_flag,
    output logic second_flag,
    output logic boot_flag,
    output logic irq,
    output logic rst_req
);
    logic first_evt;
    logic second_evt;
    logic fire_evt;

    assign first_evt  = expire && !first_flag;
    assign second_evt = expire && first_flag;
    assign fire_evt   = second_evt && !mask;

    // Flag, interrupt and reset request state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_flag  <= 1'b0;
            second_flag <= 1'b0;
            boot_flag   <= 1'b0;
            irq         <= 1'b0;
            rst_req     <= 1'b0;
        end else begin
            irq         <= first_evt;
            first_flag  <= first_evt  | (first_flag  & ~clr_first);
            second_flag <= second_evt | (second_flag & ~clr_second);
            boot_flag   <= fire_evt   | (boot_flag   & ~clr_boot);
            rst_req     <= fire_evt   | rst_req;
        end
    end

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req); // R10
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(second_flag) |-> $past(first_flag)); // R8
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(mask) == 1'b0)); // R9
endmodule

// File: rtl/wdt_twostage.sv
// Module: top of the two-stage watchdog; wires regs, counter and expiry.
// Assumes tick_en is a one-cycle pulse from an external tick source.
module wdt_twostage
    import wdt_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int MIN = MIN_LOAD,
    parameter int RST = RST_LOAD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o,
    output logic          sys_rst_req_o
);
    logic [CW-1:0] count;
    logic [CW-1:0] start_val;
    logic          reload, halt, mask, expire;
    logic          clr_first, clr_second, clr_boot;
    logic          first_flag, second_flag, boot_flag;

    wdt_regs #(.CW(CW), .DW(DW), .AW(AW), .MIN(MIN), .RST(RST)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .count(count), .first_flag(first_flag),
        .second_flag(second_flag), .boot_flag(boot_flag), .rdata(bus_rdata),
        .reload(reload), .halt(halt), .mask(mask), .start_val(start_val),
        .clr_first(clr_first), .clr_second(clr_second), .clr_boot(clr_boot)
    );

    wdt_counter #(.CW(CW), .RST(RST)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
        .reload(reload), .start_val(start_val), .count(count), .expire(expire)
    );

    wdt_expiry exp_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .mask(mask),
        .clr_first(clr_first), .clr_second(clr_second), .clr_boot(clr_boot),
        .first_flag(first_flag), .second_flag(second_flag),
        .boot_flag(boot_flag), .irq(irq_o), .rst_req(sys_rst_req_o)
    );
endmodule

// File: tb/wdt_twostage_tb_top.sv
module wdt_twostage_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 27;
    // op: 0 write, 1 read and compare, 2 run data ticks
    localparam logic [38:0] VEC [NVEC] = '{
        {2'd1, 5'h08, 16'h0000, 16'h0801},  // R1 control after reset
        {2'd1, 5'h12, 16'h0000, 16'h0004},  // R1 start value
        {2'd1, 5'h00, 16'h0000, 16'h0004},  // R1 count
        {2'd0, 5'h12, 16'h0002, 16'h0000},
        {2'd1, 5'h12, 16'h0000, 16'h0004},  // R4 short load ignored
        {2'd0, 5'h12, 16'hFC0A, 16'h0000},
        {2'd1, 5'h12, 16'h0000, 16'h000A},  // R4 low bits only
        {2'd0, 5'h00, 16'h1234, 16'h0000},
        {2'd1, 5'h00, 16'h0000, 16'h000A},  // R3 bus load
        {2'd2, 5'h00, 16'd3,    16'h0000},
        {2'd1, 5'h00, 16'h0000, 16'h000A},  // R2 halted holds
        {2'd0, 5'h08, 16'hF7FF, 16'h0000},
        {2'd1, 5'h08, 16'h0000, 16'h0001},  // R5 other bits read 0
        {2'd2, 5'h00, 16'd3,    16'h0000},
        {2'd1, 5'h00, 16'h0000, 16'h0007},  // R2 decrement
        {2'd0, 5'h08, 16'h0801, 16'h0000},
        {2'd2, 5'h00, 16'd2,    16'h0000},
        {2'd1, 5'h00, 16'h0000, 16'h0007},  // R2 frozen again
        {2'd0, 5'h08, 16'h0001, 16'h0000},
        {2'd2, 5'h00, 16'd7,    16'h0000},
        {2'd1, 5'h04, 16'h0000, 16'h0000},  // R6 no expiry yet
        {2'd2, 5'h00, 16'd1,    16'h0000},
        {2'd1, 5'h00, 16'h0000, 16'h000A},  // R6 reload on expiry
        {2'd1, 5'h04, 16'h0000, 16'h0008},  // R6 flag set
        {2'd0, 5'h04, 16'h0000, 16'h0000},
        {2'd1, 5'h04, 16'h0000, 16'h0008},  // R7 zero write ignored
        {2'd0, 5'h04, 16'h0008, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o, sys_rst_req_o;
    int          n_chk = 0;
    int          n_fail = 0;
    int          irq_seen = 0;
    logic [15:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_twostage dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
    );

    always @(negedge clk) if (rst_n && irq_o) irq_seen++;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        do_reset();
        chk("R1 irq", {15'd0, irq_o}, 16'h0);
        chk("R1 rst_req", {15'd0, sys_rst_req_o}, 16'h0);
        rd(5'h04, rv); chk("R1 sts_a", rv, 16'h0);
        rd(5'h06, rv); chk("R1 sts_b", rv, 16'h0);

        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v][38:37])
                2'd0: wr(VEC[v][36:32], VEC[v][31:16]);
                2'd1: begin
                    rd(VEC[v][36:32], rv);
                    chk($sformatf("vector %0d", v), rv, VEC[v][15:0]);
                end
                default: ticks(int'(VEC[v][31:16]));
            endcase
        end
        rd(5'h04, rv); chk("R7 one clears", rv, 16'h0);
        chk("R6 one irq", 16'(irq_seen), 16'd1);

        // First expiry then masked second expiry (start 10, count 10)
        ticks(11);
        rd(5'h04, rv); chk("R6 first again", rv, 16'h0008);
        ticks(11);
        rd(5'h06, rv); chk("R9 second flag masked", rv, 16'h0002);
        chk("R9 no request", {15'd0, sys_rst_req_o}, 16'h0);
        chk("R8 no irq on second", 16'(irq_seen), 16'd2);
        rd(5'h00, rv); chk("R8 reload on second", rv, 16'h000A);
        wr(5'h06, 16'h0002);
        rd(5'h06, rv); chk("R11 clear second", rv, 16'h0);

        // Unmasked second expiry (first flag still set)
        wr(5'h08, 16'h0000);
        ticks(11);
        chk("R8 request", {15'd0, sys_rst_req_o}, 16'h1);
        rd(5'h06, rv); chk("R8 second and boot", rv, 16'h0006);
        wr(5'h00, 16'h0000);
        wr(5'h06, 16'h0006);
        wr(5'h04, 16'h0008);
        rd(5'h06, rv); chk("R11 clear both", rv, 16'h0);
        chk("R10 sticky", {15'd0, sys_rst_req_o}, 16'h1);
        do_reset();
        chk("R10 cleared by reset", {15'd0, sys_rst_req_o}, 16'h0);

        // Same-cycle load and tick (start 4)
        wr(5'h08, 16'h0000);
        ticks(2);
        @(negedge clk); bus_addr = 5'h00; bus_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk); bus_wr = 1'b0; tick_en = 1'b0;
        rd(5'h00, rv); chk("R3 load beats tick", rv, 16'h0004);
        ticks(4);
        rd(5'h00, rv); chk("R2 reached zero", rv, 16'h0000);
        @(negedge clk); bus_addr = 5'h00; bus_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk); bus_wr = 1'b0; tick_en = 1'b0;
        rd(5'h04, rv); chk("R3 no expiry under load", rv, 16'h0);
        rd(5'h00, rv); chk("R3 count reloaded", rv, 16'h0004);
        rd(5'h12, rv); chk("R4 start after reset", rv, 16'h0004);
        finish_run();
    end
endmodule